// File: doc/BRIEF.md
# Accumulator Core with Multi-State Fetch and Execute

This block is a small processor core built around a single accumulator. A program counter, a memory address register, a memory data register, an instruction register and the accumulator are moved through a fixed chain of controller states. Each step performs one register transfer, so every memory access starts from the memory address register and passes through the memory data register. The instruction set is small: copy a memory word into the accumulator, add a memory word to it, write it back to memory, or stop.

The core drives one shared synchronous memory. It presents an address, a read strobe, a write strobe and write data, and it receives read data one cycle after the read strobe. The memory array is outside the block. Execution starts at address zero when reset is released. It continues until a stop opcode or an undefined opcode is decoded. The core then holds a halted flag and makes no further accesses until it is reset again.

Top module: `acc_cpu_core`

## Requirements
- R1: Asserting rst_ni (active low, asynchronous) clears the program counter, the address, data, instruction and accumulator registers to zero. It also puts the controller at the start of fetch. While reset is held, mem_addr_o is 0, mem_rd_o, mem_wr_o and halted_o are 0.
- R2: Each fetch first copies the program counter into the address register, which alone drives mem_addr_o. It then pulses mem_rd_o for one cycle at that address and increments the program counter by one, modulo 32. Execution starts at address 0 and instructions run in address order.
- R3: An instruction word is 8 bits. Bits [7:5] are the opcode and bits [4:0] are an operand memory address. The opcodes are 001 = LOAD, 010 = ADD, 011 = STO and 000 = HALT.
- R4: LOAD pulses mem_rd_o at the operand address and places the returned word in the accumulator.
- R5: ADD pulses mem_rd_o at the operand address and replaces the accumulator with the accumulator plus the returned word, modulo 256.
- R6: STO pulses mem_wr_o for one cycle with mem_addr_o equal to the operand address and mem_wdata_o equal to the accumulator.
- R7: Opcode 000 and the undefined opcodes 100 to 111 halt the core. halted_o then stays 1, and mem_rd_o and mem_wr_o stay 0 until reset.
- R8: Read data is sampled one cycle after the read strobe. mem_rd_o is never high in two consecutive cycles, and mem_rd_o and mem_wr_o are never high together.
- R9: Counted in clock edges from the first edge after reset release, LOAD and ADD take 8 cycles and STO takes 7 cycles. A halting opcode raises halted_o 5 cycles after its fetch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 5 | Memory address, driven from the address register |
| mem_rd_o | output | 1 | Read strobe; data is returned on the next cycle |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data, driven from the data register |
| mem_rdata_i | input | 8 | Read data from memory |
| halted_o | output | 1 | High once a stop or undefined opcode is decoded |

## Verification
All internal registers are observable only through the memory bus. A wrong program counter, instruction register or address register shows up on the next read strobe as a wrong fetch or operand address, within eight cycles. A wrong accumulator or a misplaced read-data capture only becomes visible at the next store, as a wrong write value, or as a final memory image that differs from the reference. A state sequence that is out of step shows up as a wrong total cycle count to halt, or as bus activity after halted_o has risen.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int unsigned OPC_W = 3;

  localparam logic [OPC_W-1:0] OPC_HALT = 3'b000;
  localparam logic [OPC_W-1:0] OPC_LOAD = 3'b001;
  localparam logic [OPC_W-1:0] OPC_ADD  = 3'b010;
  localparam logic [OPC_W-1:0] OPC_STO  = 3'b011;

  typedef enum logic [3:0] {
    ST_F_ADDR,
    ST_F_READ,
    ST_F_CAPT,
    ST_F_IR,
    ST_DECODE,
    ST_X_READ,
    ST_X_CAPT,
    ST_X_ACC,
    ST_X_MDR,
    ST_X_WRITE,
    ST_HALT
  } state_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_opnd;
    logic pc_inc;
    logic mdr_from_mem;
    logic mdr_from_acc;
    logic cir_load;
    logic acc_load;
    logic acc_add;
    logic rd;
    logic wr;
  } ctl_t;

endpackage

// File: rtl/acc_cpu_adder.sv
module acc_cpu_adder #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o
);

  // carry out is dropped: sum wraps modulo 2**WIDTH
  assign sum_o = a_i + b_i;

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  output ctl_t             ctl_o,
  output logic             halted_o
);

  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_F_ADDR;
    else         state_q <= state_d;
  end

  always_comb begin
    ctl_o   = '0;
    state_d = state_q;
    unique case (state_q)
      ST_F_ADDR: begin
        ctl_o.mar_from_pc = 1'b1;
        state_d = ST_F_READ;
      end
      ST_F_READ: begin
        ctl_o.rd     = 1'b1;
        ctl_o.pc_inc = 1'b1;
        state_d = ST_F_CAPT;
      end
      ST_F_CAPT: begin
        ctl_o.mdr_from_mem = 1'b1;
        state_d = ST_F_IR;
      end
      ST_F_IR: begin
        ctl_o.cir_load = 1'b1;
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        if (opcode_i == OPC_LOAD || opcode_i == OPC_ADD) begin
          ctl_o.mar_from_opnd = 1'b1;
          state_d = ST_X_READ;
        end else if (opcode_i == OPC_STO) begin
          ctl_o.mar_from_opnd = 1'b1;
          state_d = ST_X_MDR;
        end else begin
          state_d = ST_HALT;  // HALT and every undefined code
        end
      end
      ST_X_READ: begin
        ctl_o.rd = 1'b1;
        state_d = ST_X_CAPT;
      end
      ST_X_CAPT: begin
        ctl_o.mdr_from_mem = 1'b1;
        state_d = ST_X_ACC;
      end
      ST_X_ACC: begin
        ctl_o.acc_load = 1'b1;
        ctl_o.acc_add  = (opcode_i == OPC_ADD);
        state_d = ST_F_ADDR;
      end
      ST_X_MDR: begin
        ctl_o.mdr_from_acc = 1'b1;
        state_d = ST_X_WRITE;
      end
      ST_X_WRITE: begin
        ctl_o.wr = 1'b1;
        state_d = ST_F_ADDR;
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_HALT;
    endcase
  end

  assign halted_o = (state_q == ST_HALT);

  a_r7_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  a_r7_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (!ctl_o.rd && !ctl_o.wr));

  a_r8_no_rd_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctl_o.rd && ctl_o.wr));

  a_r8_rd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o.rd |=> !ctl_o.rd);

  a_r8_capture_after_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o.rd |=> ctl_o.mdr_from_mem);

endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
  import acc_cpu_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned DATA_W = OPC_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctl_t              ctl_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mdr_o,
  output logic [OPC_W-1:0]  opcode_o
);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] mdr_q;
  logic [DATA_W-1:0] cir_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] sum;
  logic [ADDR_W-1:0] operand;

  assign opcode_o = cir_q[DATA_W-1 -: OPC_W];
  assign operand  = cir_q[ADDR_W-1:0];

  acc_cpu_adder #(.WIDTH(DATA_W)) u_adder (
    .a_i  (acc_q),
    .b_i  (mdr_q),
    .sum_o(sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      cir_q <= '0;
      acc_q <= '0;
    end else begin
      if (ctl_i.pc_inc)        pc_q  <= pc_q + 1'b1;
      if (ctl_i.mar_from_pc)   mar_q <= pc_q;
      else if (ctl_i.mar_from_opnd) mar_q <= operand;
      if (ctl_i.mdr_from_mem)  mdr_q <= rdata_i;
      else if (ctl_i.mdr_from_acc) mdr_q <= acc_q;
      if (ctl_i.cir_load)      cir_q <= mdr_q;
      if (ctl_i.acc_load)      acc_q <= ctl_i.acc_add ? sum : mdr_q;
    end
  end

  assign mar_o = mar_q;
  assign mdr_o = mdr_q;

  a_r2_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_q != $past(pc_q)) |-> (pc_q == ADDR_W'($past(pc_q) + 1'b1)));

  a_r6_wdata_is_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.wr |-> (mdr_q == acc_q));

  a_r6_addr_is_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.wr |-> (mar_q == operand));

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned DATA_W = OPC_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              halted_o
);

  ctl_t             ctl;
  logic [OPC_W-1:0] opcode;

  acc_cpu_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .opcode_i(opcode),
    .ctl_o   (ctl),
    .halted_o(halted_o)
  );

  acc_cpu_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctl_i   (ctl),
    .rdata_i (mem_rdata_i),
    .mar_o   (mem_addr_o),
    .mdr_o   (mem_wdata_o),
    .opcode_o(opcode)
  );

  assign mem_rd_o = ctl.rd;
  assign mem_wr_o = ctl.wr;

endmodule

// File: tb/acc_cpu_core_bench.sv
module acc_cpu_core_bench;

  localparam int unsigned AW = 5;
  localparam int unsigned DW = 8;
  localparam int unsigned DEPTH = 1 << AW;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } ev_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] mem_addr_o;
  logic          mem_rd_o, mem_wr_o, halted_o;
  logic [DW-1:0] mem_wdata_o;
  logic [DW-1:0] mem_rdata_i = '0;

  logic [DW-1:0] mem     [DEPTH];
  logic [DW-1:0] ref_mem [DEPTH];
  ev_t           exp_q[$];
  int            checks = 0;
  int            errors = 0;
  int            cyc = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  acc_cpu_core u_acc_cpu_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mem_addr_o (mem_addr_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i),
    .halted_o   (halted_o)
  );

  // synchronous memory, one cycle read latency
  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
    if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every bus strobe must match the next queued expectation
  always @(negedge clk_i) begin
    if (rst_ni && (mem_rd_o || mem_wr_o)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 bus access with nothing expected", {mem_wr_o, mem_addr_o}, 0);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        check(mem_wr_o == e.wr && mem_rd_o == !e.wr, "R2/R4/R5/R6 strobe kind",
              {mem_rd_o, mem_wr_o}, e.wr ? 1 : 2);
        check(mem_addr_o == e.addr, "R2/R3 access address", mem_addr_o, e.addr);
        if (e.wr) check(mem_wdata_o == e.data, "R6 write data", mem_wdata_o, e.data);
        check(!(mem_rd_o && mem_wr_o), "R8 exclusive strobes", {mem_rd_o, mem_wr_o}, 0);
      end
    end
  end

  task automatic put(input int a, input logic [DW-1:0] d);
    mem[a] = d;
    ref_mem[a] = d;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < DEPTH; i++) put(i, '0);
  endtask

  // driver: interpret the program on ref_mem, queue expected bus events
  task automatic plan_run(output int cycles);
    int pc = 0;
    logic [DW-1:0] acc = '0;
    cycles = 0;
    for (int n = 0; n < 64; n++) begin
      logic [DW-1:0] ins;
      logic [2:0] op;
      logic [AW-1:0] opnd;
      exp_q.push_back('{wr: 1'b0, addr: AW'(pc), data: '0});
      ins = ref_mem[pc];
      pc = (pc + 1) % DEPTH;
      op = ins[7:5];
      opnd = ins[4:0];
      if (op == 3'b001 || op == 3'b010) begin
        exp_q.push_back('{wr: 1'b0, addr: opnd, data: '0});
        acc = (op == 3'b001) ? ref_mem[opnd] : DW'(acc + ref_mem[opnd]);
        cycles += 8;
      end else if (op == 3'b011) begin
        exp_q.push_back('{wr: 1'b1, addr: opnd, data: acc});
        ref_mem[opnd] = acc;
        cycles += 7;
      end else begin
        cycles += 5;
        break;
      end
    end
  endtask

  task automatic run_prog(input string name);
    int exp_cyc;
    int n;
    rst_ni = 1'b0;
    #1;
    check(mem_addr_o == 0 && !mem_rd_o && !mem_wr_o && !halted_o,
          {"R1 reset state ", name}, {halted_o, mem_rd_o, mem_wr_o, mem_addr_o}, 0);
    plan_run(exp_cyc);
    @(negedge clk_i);
    rst_ni = 1'b1;
    n = 0;
    while (n < 400) begin
      @(posedge clk_i);
      n++;
      @(negedge clk_i);
      if (halted_o) break;
    end
    check(n == exp_cyc, {"R9 cycles to halt ", name}, n, exp_cyc);
    repeat (10) @(negedge clk_i);
    check(halted_o == 1'b1, {"R7 halt held ", name}, halted_o, 1);
    check(exp_q.size() == 0, {"R2 all expected accesses seen ", name}, exp_q.size(), 0);
    exp_q.delete();
    for (int i = 0; i < DEPTH; i++)
      if (mem[i] !== ref_mem[i])
        check(1'b0, {"R4/R5/R6 memory image ", name}, mem[i], ref_mem[i]);
    check(1'b1, "memory image compared", 0, 0);
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk_i);

    // P1: load, add, store, halt
    put(0, 8'h25); put(1, 8'h46); put(2, 8'h67); put(3, 8'h00);
    put(5, 8'h12); put(6, 8'h34);
    run_prog("p1");
    check(mem[7] == 8'h46, "R5 p1 sum stored at 7", mem[7], 8'h46);

    // P2: repeated add with wrap, store then reload
    clear_mem();
    put(0, 8'h29); put(1, 8'h4A); put(2, 8'h4A); put(3, 8'h6B);
    put(4, 8'h2B); put(5, 8'h49); put(6, 8'h6C); put(7, 8'h00);
    put(9, 8'hF0); put(10, 8'h20);
    run_prog("p2");
    check(mem[11] == 8'h30, "R5 p2 wrapped sum", mem[11], 8'h30);
    check(mem[12] == 8'h20, "R4 p2 reload of stored value", mem[12], 8'h20);

    // P3: top address operand, undefined opcode 101 halts
    clear_mem();
    put(0, 8'h3F); put(1, 8'h5F); put(2, 8'h7E); put(3, 8'hA0); put(4, 8'h7D);
    put(31, 8'h81);
    run_prog("p3");
    check(mem[30] == 8'h02, "R3 p3 operand 31 doubled", mem[30], 8'h02);
    check(mem[29] == 8'h00, "R7 p3 nothing after undefined opcode", mem[29], 8'h00);

    // P4: store first, accumulator still zero after reset
    clear_mem();
    put(0, 8'h74); put(1, 8'hE0); put(4, 8'h5A);
    run_prog("p4");
    check(mem[20] == 8'h00, "R1 p4 accumulator cleared by reset", mem[20], 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule